// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block carries out the entry into an interrupt for a small 8-bit controller core. Hardware interrupt sources raise bits on a set vector, and those bits collect in a pending mask. The core asks for service at an instruction boundary by pulsing a service request. It can instead pulse a reset request. The sequencer looks at the global interrupt enable flag. If the flag is set, it picks a vector, saves the core's word-addressed return PC on a byte-wide stack that grows downward, and then hands the core a new PC and a new stack pointer.

The return PC is written through a single-port data-memory write interface, one byte per cycle, starting with the least significant byte. The number of bytes (1 to 3) is fixed by a parameter, and so is the vector slot size in words. While the sequence runs the block holds `busy_o` high so that the core stalls. The sequence ends with a one-cycle `done_o` pulse. In that same cycle the enable flag is cleared and only the serviced pending bit is retired.

The state machine has five states. IDLE waits for a request. PUSH0, PUSH1 and PUSH2 each write one byte of the return PC. JUMP loads the PC and the stack pointer. The transitions are:
- IDLE to PUSH0 when a request is accepted.
- PUSH0 to PUSH1, or to JUMP when the PC is one byte wide.
- PUSH1 to PUSH2, or to JUMP when the PC is two bytes wide.
- PUSH2 to JUMP.
- JUMP back to IDLE.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is in IDLE. `busy_o`, `done_o`, `mem_we_o`, `pc_load_o`, `sp_load_o`, `gie_o` and the pending mask `pend_o` are all 0.
- R2: Each bit of `irq_set_i` that is high at a clock edge is 1 in `pend_o` after that edge. This holds in every state. A bit stays set until it is serviced.
- R3: A pulse on `irq_req_i` in IDLE starts a hardware entry only when `gie_o` is 1 and `pend_o` is nonzero. Otherwise the pulse is dropped and leaves no trace.
- R4: A hardware entry serves the lowest-numbered set bit of `pend_o` and uses vector number (bit index + 1). A pulse on `rst_req_i` in IDLE while `gie_o` is 1 uses vector 0 and wins over a simultaneous `irq_req_i`. When `gie_o` is 0 the reset pulse is dropped.
- R5: `pc_o` during the load equals `VEC_BASE + vector * SLOT_WORDS`, taken modulo 2^(8*PC_BYTES).
- R6: The push makes exactly PC_BYTES writes, one per cycle, starting the cycle after acceptance. The first write goes to address `sp_i` (sampled at acceptance) with data PC[7:0]. Each later write goes to the address one lower with the next byte: PC[15:8], then PC[23:16].
- R7: `busy_o` is high from the cycle after acceptance through the JUMP cycle. In the JUMP cycle `done_o`, `pc_load_o` and `sp_load_o` are high for exactly one cycle, with `sp_o = sp_i - PC_BYTES`.
- R8: `gie_o` is 0 after the JUMP cycle, even when `gie_wr_i` is high in that cycle. In every other cycle `gie_wr_i` loads `gie_wdata_i` into `gie_o` at the next edge.
- R9: At the edge that ends JUMP, a hardware entry clears only its own pending bit. A reset entry clears no pending bit.
- R10: `irq_req_i` and `rst_req_i` are ignored outside IDLE. No second entry follows from a request raised while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_set_i | input | NUM_SRC | Sources raising pending bits |
| irq_req_i | input | 1 | Service request pulse for hardware interrupts |
| rst_req_i | input | 1 | Reset-vector request pulse |
| gie_wr_i | input | 1 | Write strobe for the global enable flag |
| gie_wdata_i | input | 1 | Value written to the global enable flag |
| pc_i | input | 8*PC_BYTES | Current word-addressed PC of the core |
| sp_i | input | SP_W | Current stack pointer of the core |
| busy_o | output | 1 | Sequence in progress, core must stall |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| gie_o | output | 1 | Global interrupt enable flag |
| pend_o | output | NUM_SRC | Pending interrupt mask |
| mem_we_o | output | 1 | Data-memory write strobe |
| mem_addr_o | output | SP_W | Data-memory write address |
| mem_wdata_o | output | 8 | Data-memory write byte |
| pc_load_o | output | 1 | Load `pc_o` into the core PC |
| pc_o | output | 8*PC_BYTES | Vector target PC |
| sp_load_o | output | 1 | Load `sp_o` into the core stack pointer |
| sp_o | output | SP_W | Stack pointer after the push |

## Verification
The hardest cases to reach from the ports are collisions at the edge that ends JUMP. One is an enable write landing in that cycle. The other is a new set on the very bit being retired, where the set must win. A directed case holds the enable write high for the whole length of one sequence. A long random phase then drives every input independently at moderate density so that these edges recur many times. A behavioural model in the bench tracks step number, pending mask, enable flag and saved PC and stack pointer, and it is compared against every output on every cycle. Fixed directed entries pin down the vector targets, the pushed byte order and the rejection of requests raised while a sequence runs.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PUSH0 = 3'd1,
        ST_PUSH1 = 3'd2,
        ST_PUSH2 = 3'd3,
        ST_JUMP  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/irq_prio_enc.sv
// Lowest-index-wins priority encoder over the pending mask.
module irq_prio_enc #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_pend_reg.sv
// Pending mask: sets OR in every cycle, one selected bit may retire.
module irq_pend_reg #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  set_i,
    input  logic          clr_en_i,
    input  logic [IW-1:0] clr_idx_i,
    output logic [N-1:0]  pend_o
);
    logic [N-1:0] clr_vec;

    for (genvar g = 0; g < N; g++) begin : g_clr
        assign clr_vec[g] = clr_en_i && (clr_idx_i == IW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= '0;
        end else begin
            pend_o <= (pend_o & ~clr_vec) | set_i;
        end
    end
endmodule

// File: rtl/irq_vec_calc.sv
// Vector number to target PC.
module irq_vec_calc #(
    parameter int             PC_W       = 16,
    parameter int             VW         = 4,
    parameter int             SLOT_WORDS = 2,
    parameter logic [PC_W-1:0] VEC_BASE  = '0
) (
    input  logic [VW-1:0]   vec_i,
    output logic [PC_W-1:0] target_o
);
    if (SLOT_WORDS == 1) begin : g_slot1
        assign target_o = VEC_BASE + PC_W'(vec_i);
    end else begin : g_slotn
        assign target_o = VEC_BASE + (PC_W'(vec_i) * PC_W'(SLOT_WORDS));
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int                      NUM_SRC    = 8,
    parameter int                      PC_BYTES   = 2,
    parameter int                      SLOT_WORDS = 2,
    parameter int                      SP_W       = 16,
    parameter logic [8*PC_BYTES-1:0]   VEC_BASE   = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      irq_set_i,
    input  logic                    irq_req_i,
    input  logic                    rst_req_i,
    input  logic                    gie_wr_i,
    input  logic                    gie_wdata_i,
    input  logic [8*PC_BYTES-1:0]   pc_i,
    input  logic [SP_W-1:0]         sp_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    gie_o,
    output logic [NUM_SRC-1:0]      pend_o,
    output logic                    mem_we_o,
    output logic [SP_W-1:0]         mem_addr_o,
    output logic [7:0]              mem_wdata_o,
    output logic                    pc_load_o,
    output logic [8*PC_BYTES-1:0]   pc_o,
    output logic                    sp_load_o,
    output logic [SP_W-1:0]         sp_o
);
    localparam int PC_W  = 8 * PC_BYTES;
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int VEC_W = $clog2(NUM_SRC + 1);

    seq_state_t        state, state_nx;
    logic [PC_W-1:0]   ret_q;
    logic [23:0]       ret_pad;
    logic [SP_W-1:0]   sp_q;
    logic [VEC_W-1:0]  vec_q;
    logic [IDX_W-1:0]  idx_q;
    logic              is_rst_q;
    logic              gie_q;

    logic              win_found;
    logic [IDX_W-1:0]  win_idx;
    logic              take_rst, take_irq, accept;
    logic              clr_en;

    irq_prio_enc #(.N(NUM_SRC), .IW(IDX_W)) u_prio (
        .req_i   (pend_o),
        .found_o (win_found),
        .idx_o   (win_idx)
    );

    irq_pend_reg #(.N(NUM_SRC), .IW(IDX_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (irq_set_i),
        .clr_en_i  (clr_en),
        .clr_idx_i (idx_q),
        .pend_o    (pend_o)
    );

    irq_vec_calc #(
        .PC_W       (PC_W),
        .VW         (VEC_W),
        .SLOT_WORDS (SLOT_WORDS),
        .VEC_BASE   (VEC_BASE)
    ) u_vec (
        .vec_i    (vec_q),
        .target_o (pc_o)
    );

    // Acceptance: reset wins; both need the enable flag.
    assign take_rst = (state == ST_IDLE) && rst_req_i && gie_q;
    assign take_irq = (state == ST_IDLE) && !take_rst && irq_req_i
                      && gie_q && win_found;
    assign accept   = take_rst || take_irq;
    assign clr_en   = (state == ST_JUMP) && !is_rst_q;
    assign ret_pad  = 24'(ret_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_PUSH0;
            ST_PUSH0: state_nx = (PC_BYTES > 1) ? ST_PUSH1 : ST_JUMP;
            ST_PUSH1: state_nx = (PC_BYTES > 2) ? ST_PUSH2 : ST_JUMP;
            ST_PUSH2: state_nx = ST_JUMP;
            ST_JUMP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o      = 1'b1;
        done_o      = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = 8'h00;
        pc_load_o   = 1'b0;
        sp_load_o   = 1'b0;
        unique case (state)
            ST_IDLE: busy_o = 1'b0;
            ST_PUSH0: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = ret_pad[7:0];
            end
            ST_PUSH1: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = ret_pad[15:8];
            end
            ST_PUSH2: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = ret_pad[23:16];
            end
            ST_JUMP: begin
                done_o    = 1'b1;
                pc_load_o = 1'b1;
                sp_load_o = 1'b1;
            end
            default: busy_o = 1'b0;
        endcase
    end

    assign mem_addr_o = sp_q;
    assign sp_o       = sp_q;
    assign gie_o      = gie_q;

    // Sequence datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_q    <= '0;
            sp_q     <= '0;
            vec_q    <= '0;
            idx_q    <= '0;
            is_rst_q <= 1'b0;
        end else if (accept) begin
            ret_q    <= pc_i;
            sp_q     <= sp_i;
            idx_q    <= win_idx;
            is_rst_q <= take_rst;
            vec_q    <= take_rst ? '0 : (VEC_W'(win_idx) + VEC_W'(1));
        end else if (mem_we_o) begin
            sp_q <= sp_q - SP_W'(1);
        end
    end

    // Global enable flag: JUMP clears it over any write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
        end else if (state == ST_JUMP) begin
            gie_q <= 1'b0;
        end else if (gie_wr_i) begin
            gie_q <= gie_wdata_i;
        end
    end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
    parameter int NUM_SRC  = 8,
    parameter int PC_BYTES = 2,
    parameter int SP_W     = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_set_i,
    input logic               busy_o,
    input logic               done_o,
    input logic               gie_o,
    input logic [NUM_SRC-1:0] pend_o,
    input logic               mem_we_o,
    input logic [SP_W-1:0]    mem_addr_o,
    input logic               pc_load_o,
    input logic               sp_load_o
);
    logic [2:0] wr_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= '0;
        end else if (done_o) begin
            wr_cnt <= '0;
        end else if (mem_we_o) begin
            wr_cnt <= wr_cnt + 3'd1;
        end
    end

    assert_set_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_set_i) |=> ((pend_o & $past(irq_set_i)) == $past(irq_set_i)));

    assert_entry_needs_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(gie_o));

    assert_push_stride_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == ($past(mem_addr_o) - SP_W'(1))));

    assert_push_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (wr_cnt == 3'(PC_BYTES)));

    assert_we_in_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    assert_load_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pc_load_o && sp_load_o));

    assert_gie_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !gie_o);
endmodule

bind irq_entry_seq irq_seq_chk #(
    .NUM_SRC  (NUM_SRC),
    .PC_BYTES (PC_BYTES),
    .SP_W     (SP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_set_i  (irq_set_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .gie_o      (gie_o),
    .pend_o     (pend_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .pc_load_o  (pc_load_o),
    .sp_load_o  (sp_load_o)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
    localparam int          NSRC = 8;
    localparam int          PCB  = 3;
    localparam int          SLOT = 2;
    localparam int          SPW  = 16;
    localparam logic [23:0] BASE = 24'h000010;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_set = '0;
    logic            irq_req = 1'b0, rst_req = 1'b0;
    logic            gie_wr = 1'b0, gie_wdata = 1'b0;
    logic [23:0]     pc_in = '0;
    logic [SPW-1:0]  sp_in = '0;
    logic            busy, done, gie, mem_we, pc_load, sp_load;
    logic [NSRC-1:0] pend;
    logic [SPW-1:0]  mem_addr, sp_out;
    logic [7:0]      mem_wdata;
    logic [23:0]     pc_out;

    irq_entry_seq #(
        .NUM_SRC(NSRC), .PC_BYTES(PCB), .SLOT_WORDS(SLOT), .SP_W(SPW), .VEC_BASE(BASE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .irq_set_i(irq_set), .irq_req_i(irq_req),
        .rst_req_i(rst_req), .gie_wr_i(gie_wr), .gie_wdata_i(gie_wdata),
        .pc_i(pc_in), .sp_i(sp_in), .busy_o(busy), .done_o(done), .gie_o(gie),
        .pend_o(pend), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .pc_load_o(pc_load), .pc_o(pc_out),
        .sp_load_o(sp_load), .sp_o(sp_out)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cycles = 0, n_done = 0;
    logic [23:0] last_pc = '0;
    logic [15:0] last_sp = '0;
    logic [7:0]  mem [int];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int          m_step = 0;
    logic [7:0]  m_pend = '0;
    bit          m_gie = 0, m_isrst = 0;
    int          m_vec = 0, m_idx = 0;
    longint      m_ret = 0, m_sp = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = 0; m_pend = '0; m_gie = 0; m_vec = 0; m_isrst = 0;
        end else begin
            logic [7:0] clr;
            bit jmp;
            clr = '0;
            jmp = (m_step == PCB + 1);
            if (m_step == 0) begin
                bit start;
                start = 0;
                if (rst_req && m_gie) begin
                    m_isrst = 1; m_vec = 0; start = 1;
                end else if (irq_req && m_gie && m_pend != 0) begin
                    for (int i = NSRC - 1; i >= 0; i--) if (m_pend[i]) m_idx = i;
                    m_vec = m_idx + 1; m_isrst = 0; start = 1;
                end
                if (start) begin
                    m_ret = pc_in; m_sp = sp_in; m_step = 1;
                end
            end else if (jmp) begin
                m_step = 0;
                if (!m_isrst) clr[m_idx] = 1'b1;
            end else begin
                m_step++;
            end
            if (jmp) m_gie = 0;
            else if (gie_wr) m_gie = gie_wdata;
            m_pend = (m_pend & ~clr) | irq_set;
        end
    end

    // Every-cycle comparison and logging
    always @(negedge clk) begin
        longint ea, ed, ep, es;
        check(busy == (m_step != 0), "R7 busy", busy, m_step != 0);
        check(gie == m_gie, "R8 gie", gie, m_gie);
        check(pend == m_pend, "R2 R9 pending", pend, m_pend);
        if (m_step >= 1 && m_step <= PCB) begin
            ea = (m_sp - (m_step - 1)) & 16'hffff;
            ed = (m_ret >> (8 * (m_step - 1))) & 8'hff;
            check(mem_we == 1'b1, "R6 write strobe", mem_we, 1);
            check(mem_addr == ea, "R6 write address", mem_addr, ea);
            check(mem_wdata == ed, "R6 write data", mem_wdata, ed);
        end else begin
            check(mem_we == 1'b0, "R6 no write", mem_we, 0);
        end
        if (m_step == PCB + 1) begin
            ep = (BASE + m_vec * SLOT) & 24'hffffff;
            es = (m_sp - PCB) & 16'hffff;
            check(done && pc_load && sp_load, "R7 load pulse", {done, pc_load, sp_load}, 7);
            check(pc_out == ep, "R5 target pc", pc_out, ep);
            check(sp_out == es, "R7 new sp", sp_out, es);
        end else begin
            check(!done && !pc_load && !sp_load, "R7 no load", {done, pc_load, sp_load}, 0);
        end
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
        if (pc_load) begin
            last_pc = pc_out; last_sp = sp_out; n_done++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_gie();
        gie_wr = 1; gie_wdata = 1; step(1); gie_wr = 0;
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R1: reset state
        check(!busy && !gie && pend == 0 && !mem_we && !done, "R1 reset state",
              {busy, gie, pend}, 0);

        // R3: requests with enable clear are dropped
        irq_set = 8'h28; irq_req = 1; step(1);
        irq_set = 0; irq_req = 0; step(3);
        check(n_done == 0 && !busy, "R3 no entry while disabled", n_done, 0);
        check(pend == 8'h28, "R2 pending collected", pend, 8'h28);

        // R4 R5 R6: service bit 3, vector 4; R10: requests during sequence ignored
        set_gie();
        pc_in = 24'hABCDEF; sp_in = 16'h08FF; irq_req = 1; step(1);
        irq_req = 1; rst_req = 1; irq_set = 8'h02; step(1);
        irq_req = 1; rst_req = 1; irq_set = 0; step(1);
        irq_req = 0; rst_req = 0; step(6);
        check(last_pc == 24'h000018, "R4 R5 lowest bit vector", last_pc, 24'h18);
        check(last_sp == 16'h08FC, "R7 sp after push", last_sp, 16'h08FC);
        check(mem[16'h08FF] == 8'hEF, "R6 byte0", mem[16'h08FF], 8'hEF);
        check(mem[16'h08FE] == 8'hCD, "R6 byte1", mem[16'h08FE], 8'hCD);
        check(mem[16'h08FD] == 8'hAB, "R6 byte2", mem[16'h08FD], 8'hAB);
        check(pend == 8'h22, "R9 only serviced bit cleared", pend, 8'h22);
        check(n_done == 1, "R10 busy-time requests ignored", n_done, 1);
        check(!gie, "R8 enable cleared", gie, 0);

        // R4: reset wins, vector 0; R8: write held through JUMP is overridden
        set_gie();
        pc_in = 24'h000123; sp_in = 16'h0400; rst_req = 1; irq_req = 1;
        gie_wr = 1; gie_wdata = 1; step(1);
        rst_req = 0; irq_req = 0; step(4);
        gie_wr = 0; step(1);
        check(!gie, "R8 JUMP overrides enable write", gie, 0);
        check(last_pc == 24'h000010, "R4 reset vector 0", last_pc, 24'h10);
        check(pend == 8'h22, "R9 reset entry keeps pending", pend, 8'h22);
        step(2);

        // R4: next lowest bit 1 -> vector 2, then bit 5 -> vector 6
        set_gie(); irq_req = 1; step(1); irq_req = 0; step(6);
        check(last_pc == 24'h000014, "R4 bit1 vector 2", last_pc, 24'h14);
        set_gie(); irq_req = 1; step(1); irq_req = 0; step(6);
        check(last_pc == 24'h00001C, "R4 bit5 vector 6", last_pc, 24'h1C);
        check(pend == 8'h00, "R9 all serviced", pend, 0);

        // R3: enabled but empty mask
        set_gie(); irq_req = 1; step(1); irq_req = 0; step(3);
        check(n_done == 4 && gie, "R3 empty mask no entry", n_done, 4);

        // Random phase, model compared every cycle
        for (int k = 0; k < 4000; k++) begin
            irq_set   = ($urandom % 6 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            irq_req   = ($urandom % 3 == 0);
            rst_req   = ($urandom % 12 == 0);
            gie_wr    = ($urandom % 4 == 0);
            gie_wdata = ($urandom % 4 != 0);
            pc_in     = 24'($urandom);
            sp_in     = 16'($urandom);
            step(1);
        end
        irq_set = 0; irq_req = 0; rst_req = 0; gie_wr = 0;
        step(6);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule